// File: doc/BRIEF.md
# Automatic Sampling-Phase Search Sequencer

This block finds the sampling phase that gives the strongest (or the weakest) picture-quality reading. It walks a 6-bit phase code from 0 up to 63. The code stays at each value for a fixed number of frames, counted in VSYNC pulses. An external accumulator supplies one quality value per frame. The sequencer adds up those values over each step and keeps the phase whose total wins. The value is sampled in the same cycle as the VSYNC pulse.

Software starts a search with a one-cycle start request. The search target and the dwell length are taken from control bits at that moment. The phase that the sampler should use is presented on a separate output. That output can follow the working phase at once, or it can change only on frame boundaries. A soft-reset input returns everything to the idle state. Software raises it and then lowers it again.

Top module: `phase_search_seq`

## Requirements
- R1: After `rst_n` is low at a clock edge, `trial_phase`, `best_phase` and `applied_phase` are 0 and `done` is 0.
- R2: A `start` pulse accepted while no search is running clears `done` and sets `trial_phase` to 0 at the next edge. `trial_phase` then rises by exactly 1 at the edge that ends each step, and changes at no other time during a search.
- R3: The length of a step, in VSYNC pulses, is taken from `slow_dwell` at start: 0 selects 28 pulses and 1 selects 64 pulses.
- R4: The score of a step is the sum of `metric` sampled on every cycle in which `vsync` is 1 during that step, the final pulse of the step included.
- R5: With `seek_worst` = 0 at start, `best_phase` ends as the step with the largest score. With `seek_worst` = 1 at start, it ends as the step with the smallest score.
- R6: When two step scores tie, the lower phase code is kept.
- R7: `done` is 1 from the cycle after the final VSYNC pulse of phase 63. It stays 1 until the next accepted `start` or `soft_rst`. `done` is never 1 while a search is running.
- R8: A `start` pulse during a running search has no effect on `trial_phase` or on the result.
- R9: While `soft_rst` is 1, all outputs are cleared to 0 at every edge and `start` is ignored. After `soft_rst` returns to 0, no search runs until a new `start` is given.
- R10: The target phase is `trial_phase` while a search runs and `best_phase` otherwise. With `defer_apply` = 0, `applied_phase` takes the target one cycle after the target changes. With `defer_apply` = 1, `applied_phase` loads the target only at the edge of a `vsync` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vsync | input | 1 | One-cycle frame pulse; `metric` is valid in the same cycle |
| metric | input | METRIC_W | Per-frame quality value |
| start | input | 1 | Search request pulse |
| seek_worst | input | 1 | 0: search for maximum score, 1: search for minimum |
| slow_dwell | input | 1 | 0: 28 frames per step, 1: 64 frames per step |
| defer_apply | input | 1 | 1 (normal setting): applied phase changes only on VSYNC |
| soft_rst | input | 1 | Holds the sequencer idle and cleared while 1 |
| trial_phase | output | PHASE_W | Phase currently under test |
| best_phase | output | PHASE_W | Winning phase so far / final result |
| applied_phase | output | PHASE_W | Phase to drive into the sampler |
| done | output | 1 | Search complete |

## Verification
A step ends on the edge of the final VSYNC pulse of that step. From that edge on, `trial_phase`, `best_phase` and `done` show their new values. The bench therefore samples them at the falling edge right after that pulse, and checks `done` low at the falling edge just before it.

In immediate mode, `applied_phase` lags the target by one more register. It is checked first at that same falling edge, where it still holds the old value, and again one cycle later. In deferred mode it is checked across several idle cycles and then once more after the next pulse. Expected winners are computed in the bench from its own per-frame stimulus sums.

// File: rtl/phase_search_seq.sv
module phase_search_seq #(
  parameter int PHASE_W    = 6,
  parameter int METRIC_W   = 12,
  parameter int FAST_DWELL = 28,
  parameter int SLOW_DWELL = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                vsync,
  input  logic [METRIC_W-1:0] metric,
  input  logic                start,
  input  logic                seek_worst,
  input  logic                slow_dwell,
  input  logic                defer_apply,
  input  logic                soft_rst,
  output logic [PHASE_W-1:0]  trial_phase,
  output logic [PHASE_W-1:0]  best_phase,
  output logic [PHASE_W-1:0]  applied_phase,
  output logic                done
);
  localparam int SUM_W = METRIC_W + $clog2(SLOW_DWELL + 1);
  localparam int CNT_W = $clog2(SLOW_DWELL);
  localparam logic [PHASE_W-1:0] LAST_PHASE = '1;
  localparam logic [CNT_W-1:0]   FAST_LAST  = CNT_W'(FAST_DWELL - 1);
  localparam logic [CNT_W-1:0]   SLOW_LAST  = CNT_W'(SLOW_DWELL - 1);

  logic               busy, mode_worst, mode_slow, have_best;
  logic [CNT_W-1:0]   frame_cnt;
  logic [SUM_W-1:0]   acc, best_sum;

  wire [SUM_W-1:0]   step_sum   = acc + SUM_W'(metric);
  wire [CNT_W-1:0]   last_frame = mode_slow ? SLOW_LAST : FAST_LAST;
  wire               step_end   = busy && vsync && (frame_cnt == last_frame);
  wire               better     = !have_best ||
                                  (mode_worst ? (step_sum < best_sum) : (step_sum > best_sum));
  wire [PHASE_W-1:0] target     = busy ? trial_phase : best_phase;

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst) begin
      busy          <= 1'b0;
      done          <= 1'b0;
      mode_worst    <= 1'b0;
      mode_slow     <= 1'b0;
      have_best     <= 1'b0;
      frame_cnt     <= '0;
      acc           <= '0;
      best_sum      <= '0;
      trial_phase   <= '0;
      best_phase    <= '0;
      applied_phase <= '0;
    end else begin
      if (start && !busy) begin
        busy        <= 1'b1;
        done        <= 1'b0;
        have_best   <= 1'b0;
        frame_cnt   <= '0;
        acc         <= '0;
        trial_phase <= '0;
        mode_worst  <= seek_worst;
        mode_slow   <= slow_dwell;
      end else if (busy && vsync) begin
        if (step_end) begin
          frame_cnt <= '0;
          acc       <= '0;
          if (better) begin
            best_sum   <= step_sum;
            best_phase <= trial_phase;
            have_best  <= 1'b1;
          end
          if (trial_phase == LAST_PHASE) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            trial_phase <= trial_phase + 1'b1;
          end
        end else begin
          frame_cnt <= frame_cnt + 1'b1;
          acc       <= step_sum;
        end
      end
      if (!defer_apply || vsync) applied_phase <= target;
    end
  end

  AST_TRIAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !vsync && !soft_rst |=> $stable(trial_phase)); // R2
  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    step_end && !soft_rst && trial_phase != LAST_PHASE |=>
      trial_phase == PHASE_W'($past(trial_phase) + 1'b1)); // R2
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !vsync && !soft_rst |=> busy && $stable(trial_phase)); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start && !soft_rst |=> done); // R7
  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !done && !busy && trial_phase == '0 && best_phase == '0 && applied_phase == '0); // R9
  AST_DEFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    defer_apply && !vsync && !soft_rst |=> $stable(applied_phase)); // R10
endmodule

// File: tb/phase_search_seq_tb.sv
module phase_search_seq_tb_top;
  localparam int PW = 6;
  localparam int MW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vsync = 1'b0;
  logic [MW-1:0] metric = '0;
  logic start = 1'b0, seek_worst = 1'b0, slow_dwell = 1'b0;
  logic defer_apply = 1'b1, soft_rst = 1'b0;
  logic [PW-1:0] trial_phase, best_phase, applied_phase;
  logic done;

  int n_checks = 0;
  int n_errors = 0;

  always #4 clk = ~clk;

  phase_search_seq dut_i (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .metric(metric), .start(start),
    .seek_worst(seek_worst), .slow_dwell(slow_dwell), .defer_apply(defer_apply),
    .soft_rst(soft_rst), .trial_phase(trial_phase), .best_phase(best_phase),
    .applied_phase(applied_phase), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int metric_of(input int pat, input int s, input int f, input int dw);
    case (pat)
      0:       return ((s * 37) % 64) + 5;
      1:       return (s == 20 || s == 45) ? 500 : ((s == 10 || s == 50) ? 1 : 50);
      default: return (s == 50 && f == dw - 1) ? 1000 : 10;
    endcase
  endfunction

  task automatic vs(input int val, input int gap);
    vsync = 1'b1;
    metric = MW'(val);
    @(negedge clk);
    vsync = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_search(input bit worst, input bit slow, input int pat,
                            input bit inject, input string tag);
    int dw = slow ? 64 : 28;
    int exp_ph = 0;
    int exp_sum = 0;
    for (int s = 0; s < 64; s++) begin
      int sum = 0;
      for (int f = 0; f < dw; f++) sum += metric_of(pat, s, f, dw);
      if (s == 0 || (worst ? sum < exp_sum : sum > exp_sum)) begin
        exp_ph = s;
        exp_sum = sum;
      end
    end
    defer_apply = 1'b0;
    seek_worst = worst;
    slow_dwell = slow;
    pulse_start();
    chk(done == 1'b0, "R2 done cleared by start", int'(done), 0);
    for (int s = 0; s < 64; s++) begin
      for (int f = 0; f < dw; f++) begin
        if (f == 0) chk(trial_phase == PW'(s), "R2/R3 trial phase at step start", int'(trial_phase), s);
        if (inject && s == 3 && f == 5) begin
          pulse_start();
          chk(trial_phase == 3, "R8 start during search ignored", int'(trial_phase), 3);
        end
        if (s == 63 && f == dw - 1) chk(done == 1'b0, "R7 done low before final vsync", int'(done), 0);
        vs(metric_of(pat, s, f, dw), (s == 63 && f == dw - 1) ? 0 : 2);
      end
    end
    chk(done == 1'b1, "R7 done after final step", int'(done), 1);
    chk(best_phase == PW'(exp_ph), tag, int'(best_phase), exp_ph);
    @(negedge clk);
    chk(applied_phase == PW'(exp_ph), "R10 applied follows result", int'(applied_phase), exp_ph);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(trial_phase == 0, "R1 reset trial", int'(trial_phase), 0);
    chk(best_phase == 0, "R1 reset best", int'(best_phase), 0);
    chk(applied_phase == 0, "R1 reset applied", int'(applied_phase), 0);
    chk(done == 1'b0, "R1 reset done", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_done_sticky();
    for (int i = 0; i < 5; i++) vs(7, 2);
    chk(done == 1'b1, "R7 done held while idle", int'(done), 1);
    pulse_start();
    chk(done == 1'b0, "R2 new start clears done", int'(done), 0);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_soft_reset();
    seek_worst = 1'b0;
    slow_dwell = 1'b0;
    pulse_start();
    for (int i = 0; i < 40; i++) vs(100, 2);
    chk(trial_phase == 1, "R9 search running before soft reset", int'(trial_phase), 1);
    soft_rst = 1'b1;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk(trial_phase == 0 && done == 1'b0, "R9 soft reset clears state", int'(trial_phase), 0);
    chk(best_phase == 0, "R9 soft reset clears result", int'(best_phase), 0);
    soft_rst = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 60; i++) vs(100, 2);
    chk(trial_phase == 0, "R9 no search after release without start", int'(trial_phase), 0);
    chk(done == 1'b0, "R9 done stays low after release", int'(done), 0);
  endtask

  task automatic t_apply();
    defer_apply = 1'b0;
    slow_dwell = 1'b0;
    pulse_start();
    for (int i = 0; i < 27; i++) vs(0, 2);
    vs(0, 0);
    chk(trial_phase == 1, "R2 step advance", int'(trial_phase), 1);
    chk(applied_phase == 0, "R10 immediate mode lag of one cycle", int'(applied_phase), 0);
    @(negedge clk);
    chk(applied_phase == 1, "R10 immediate mode update", int'(applied_phase), 1);
    defer_apply = 1'b1;
    for (int i = 0; i < 27; i++) vs(0, 2);
    vs(0, 0);
    chk(trial_phase == 2, "R2 second step advance", int'(trial_phase), 2);
    repeat (5) @(negedge clk);
    chk(applied_phase == 1, "R10 deferred mode holds until vsync", int'(applied_phase), 1);
    vs(0, 0);
    chk(applied_phase == 2, "R10 deferred mode loads on vsync", int'(applied_phase), 2);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    run_search(1'b0, 1'b0, 0, 1'b0, "R5 best phase, max score");
    t_done_sticky();
    run_search(1'b1, 1'b0, 0, 1'b1, "R5/R8 worst phase, min score");
    run_search(1'b0, 1'b0, 1, 1'b0, "R6 tie on max keeps lower phase");
    run_search(1'b1, 1'b0, 1, 1'b0, "R6 tie on min keeps lower phase");
    run_search(1'b1, 1'b0, 2, 1'b0, "R6 all-equal scores keep phase 0");
    run_search(1'b0, 1'b1, 2, 1'b0, "R3/R4 slow dwell, last-frame value counted");
    t_soft_reset();
    t_apply();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule